// File: doc/BRIEF.md
# Indirect SerDes Register Access Engine

This block lets software reach the configuration registers of a set of SerDes lanes through just two words of register space. It holds a command word and a data word. To write, software loads the data word with the value and then writes the command word with a write command and the start bit set. To read, software writes a read command with the start bit set. Software then polls the command word until bit 0 reads back as zero. For a read, it then takes the result from the data word.

The engine latches the lane, page, register and direction fields from the command word. It keeps the start bit high as a busy flag for a fixed number of cycles, set by a parameter. In the last busy cycle it issues a single one-cycle access on its internal register-file port. A read result is captured into bits 15:0 of the data word at that moment, and the busy flag drops on the same clock edge.

While an operation is in progress, writes to either word are dropped. A command that names a lane with no register file finishes normally but performs no access, and a read of such a lane returns zero.

Top module: `sds_indirect_engine`

## Requirements
- R1: After reset the command word and the data word read as zero, and the access strobe `sds_en_o` is low.
- R2: `csr_sel_i` = 0 addresses the command word and 1 addresses the data word. The command word has these fields: bit 0 is start/busy, bit 1 is direction (1 = write, 0 = read), bits 6:2 are the lane, bits 12:7 are the page and bits 17:13 are the register. After an accepted command write, the word reads back with the written fields and with bit 0 equal to the busy flag.
- R3: A command write with bit 0 set, made while idle, raises busy on the next clock edge. Busy then stays set for exactly ACCESS_LAT clock cycles and clears by itself.
- R4: Each started command with a legal lane produces exactly one single-cycle `sds_en_o` pulse, in the last busy cycle. The pulse carries the latched lane, page, register and direction, and `sds_wdata_o` equal to the data word.
- R5: When a read completes, the value returned on `sds_rdata_i` appears in bits 15:0 of the data word on the same edge that clears busy.
- R6: A command write that arrives while busy is ignored. The latched fields, the timing and the access of the running operation are unchanged.
- R7: A data-word write that arrives while busy is ignored. A running write stores the value that was loaded before the command.
- R8: Bits 31:18 of the command word and bits 31:16 of the data word always read as zero.
- R9: A command whose lane is NUM_LANES or above still holds busy for ACCESS_LAT cycles, but makes no access. If it is a read, the data word becomes zero.
- R10: A command write with bit 0 clear, made while idle, records the fields but starts nothing: busy stays clear and no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | 0 = command word, 1 = data word |
| csr_wdata_i | input | 32 | Register write data |
| cmd_rdata_o | output | 32 | Command word read value |
| data_rdata_o | output | 32 | Data word read value |
| sds_en_o | output | 1 | One-cycle access strobe to the register files |
| sds_we_o | output | 1 | Access direction, 1 = write |
| sds_lane_o | output | 5 | Lane of the access |
| sds_page_o | output | 6 | Page of the access |
| sds_reg_o | output | 5 | Register of the access |
| sds_wdata_o | output | 16 | Write data of the access |
| sds_rdata_i | input | 16 | Read data returned in the strobe cycle |

## Verification
The bench builds the engine with ACCESS_LAT = 3 and NUM_LANES = 12. The short latency keeps each poll loop brief, yet it leaves two idle-busy cycles in which to inject a stray command or data write before the access fires. With twelve lanes, lanes 11 and 12 sit either side of the legal edge, and lane 20 exercises an illegal value deep inside the 5-bit field.

// File: rtl/sds_acc_pkg.sv
package sds_acc_pkg;
  localparam int START_BIT = 0;
  localparam int WR_BIT    = 1;
  localparam int LANE_LSB  = 2;
  localparam int LANE_W    = 5;
  localparam int PAGE_LSB  = 7;
  localparam int PAGE_W    = 6;
  localparam int REG_LSB   = 13;
  localparam int REG_W     = 5;
  localparam int USED_W    = REG_LSB + REG_W;
  localparam int DATA_W    = 16;
  localparam int CSR_W     = 32;

  // field order matches the command word above bit 0
  typedef struct packed {
    logic [REG_W-1:0]  regn;
    logic [PAGE_W-1:0] page;
    logic [LANE_W-1:0] lane;
    logic              wr;
  } sds_cmd_t;
endpackage

// File: rtl/sds_cmd_decode.sv
module sds_cmd_decode
  import sds_acc_pkg::*;
(
  input  logic [CSR_W-1:0] word_i,
  output sds_cmd_t         cmd_o,
  output logic             start_o
);
  always_comb begin
    cmd_o.wr   = word_i[WR_BIT];
    cmd_o.lane = word_i[LANE_LSB +: LANE_W];
    cmd_o.page = word_i[PAGE_LSB +: PAGE_W];
    cmd_o.regn = word_i[REG_LSB  +: REG_W];
    start_o    = word_i[START_BIT];
  end
endmodule

// File: rtl/sds_acc_seq.sv
module sds_acc_seq
  import sds_acc_pkg::*;
#(
  parameter int ACCESS_LAT = 4,
  parameter int NUM_LANES  = 12
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_wr_i,
  input  sds_cmd_t cmd_i,
  input  logic     start_i,
  output sds_cmd_t cmd_q_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     legal_o,
  output logic     port_en_o
);
  localparam int CNT_W = (ACCESS_LAT > 1) ? $clog2(ACCESS_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_LAT - 1);
  localparam logic [LANE_W:0]  LANE_LIM = (LANE_W+1)'(NUM_LANES);

  sds_cmd_t         cmd_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (cmd_wr_i) begin
        cmd_q <= cmd_i;
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_LOAD;
        end
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign legal_o   = {1'b0, cmd_q.lane} < LANE_LIM;
  assign done_o    = busy_q && (cnt_q == '0);
  assign port_en_o = done_o && legal_o;
  assign busy_o    = busy_q;
  assign cmd_q_o   = cmd_q;

  // R3
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  // R3
  busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> cnt_q == CNT_LOAD);
  // R4
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_o |=> !port_en_o);
  // R6
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_q));
endmodule

// File: rtl/sds_data_reg.sv
module sds_data_reg
  import sds_acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              rd_i,
  input  logic              legal_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (done_i && rd_i) begin
      data_q <= legal_i ? rdata_i : '0;
    end else if (bus_wr_i && !busy_i) begin
      data_q <= bus_wdata_i;
    end
  end

  assign data_o = data_q;

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> $stable(data_q));
  // R9
  illegal_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rd_i && !legal_i) |=> (data_q == '0));
  // R5
  rd_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rd_i && legal_i) |=> (data_q == $past(rdata_i)));
endmodule

// File: rtl/sds_indirect_engine.sv
module sds_indirect_engine
  import sds_acc_pkg::*;
#(
  parameter int ACCESS_LAT = 4,
  parameter int NUM_LANES  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic              csr_sel_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  cmd_rdata_o,
  output logic [CSR_W-1:0]  data_rdata_o,
  output logic              sds_en_o,
  output logic              sds_we_o,
  output logic [LANE_W-1:0] sds_lane_o,
  output logic [PAGE_W-1:0] sds_page_o,
  output logic [REG_W-1:0]  sds_reg_o,
  output logic [DATA_W-1:0] sds_wdata_o,
  input  logic [DATA_W-1:0] sds_rdata_i
);
  sds_cmd_t          dec_cmd, cmd_q;
  logic              dec_start, busy, done, legal, port_en;
  logic [DATA_W-1:0] data_q;

  sds_cmd_decode u_dec (
    .word_i  (csr_wdata_i),
    .cmd_o   (dec_cmd),
    .start_o (dec_start)
  );

  sds_acc_seq #(
    .ACCESS_LAT (ACCESS_LAT),
    .NUM_LANES  (NUM_LANES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (csr_wr_i && !csr_sel_i),
    .cmd_i     (dec_cmd),
    .start_i   (dec_start),
    .cmd_q_o   (cmd_q),
    .busy_o    (busy),
    .done_o    (done),
    .legal_o   (legal),
    .port_en_o (port_en)
  );

  sds_data_reg u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (csr_wr_i && csr_sel_i),
    .bus_wdata_i (csr_wdata_i[DATA_W-1:0]),
    .busy_i      (busy),
    .done_i      (done),
    .rd_i        (!cmd_q.wr),
    .legal_i     (legal),
    .rdata_i     (sds_rdata_i),
    .data_o      (data_q)
  );

  assign cmd_rdata_o  = {{(CSR_W-USED_W){1'b0}}, cmd_q, busy};
  assign data_rdata_o = {{(CSR_W-DATA_W){1'b0}}, data_q};
  assign sds_en_o     = port_en;
  assign sds_we_o     = cmd_q.wr;
  assign sds_lane_o   = cmd_q.lane;
  assign sds_page_o   = cmd_q.page;
  assign sds_reg_o    = cmd_q.regn;
  assign sds_wdata_o  = data_q;

  // R4
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sds_en_o |-> cmd_rdata_o[0]);
  // R10
  idle_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_rdata_o[0] && csr_wr_i && !csr_sel_i && !csr_wdata_i[0]) |=> !cmd_rdata_o[0]);
endmodule

// File: tb/tb_sds_indirect_engine.sv
`timescale 1ns/1ps
module tb_sds_indirect_engine;
  localparam int LAT   = 3;
  localparam int LANES = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0, csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] cmd_rd, data_rd;
  logic        sds_en, sds_we;
  logic [4:0]  sds_lane, sds_reg;
  logic [5:0]  sds_page;
  logic [15:0] sds_wdata, sds_rdata;

  always #10 clk = ~clk;

  sds_indirect_engine #(.ACCESS_LAT(LAT), .NUM_LANES(LANES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_wr_i(csr_wr), .csr_sel_i(csr_sel),
    .csr_wdata_i(csr_wdata), .cmd_rdata_o(cmd_rd), .data_rdata_o(data_rd),
    .sds_en_o(sds_en), .sds_we_o(sds_we), .sds_lane_o(sds_lane),
    .sds_page_o(sds_page), .sds_reg_o(sds_reg), .sds_wdata_o(sds_wdata),
    .sds_rdata_i(sds_rdata));

  // register-file model: written cells override a computed pattern
  logic [15:0] mem_val [2048];
  logic        mem_vld [2048];
  int          strobes;
  logic [16:0] last_acc;

  function automatic logic [10:0] h(input logic [4:0] l, input logic [5:0] p, input logic [4:0] r);
    return {l[3:0], p[2:0], r[3:0]};
  endfunction
  function automatic logic [15:0] pat(input logic [10:0] i);
    return 16'(32'(i) * 263) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] mem_rd(input logic [4:0] l, input logic [5:0] p, input logic [4:0] r);
    return mem_vld[h(l, p, r)] ? mem_val[h(l, p, r)] : pat(h(l, p, r));
  endfunction

  assign sds_rdata = mem_rd(sds_lane, sds_page, sds_reg);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem_vld[i] <= 1'b0;
      strobes  <= 0;
      last_acc <= '0;
    end else if (sds_en) begin
      strobes  <= strobes + 1;
      last_acc <= {sds_reg, sds_page, sds_lane, sds_we};
      if (sds_we) begin
        mem_val[h(sds_lane, sds_page, sds_reg)] <= sds_wdata;
        mem_vld[h(sds_lane, sds_page, sds_reg)] <= 1'b1;
      end
    end
  end

  int n_cmp = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] d);
    csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rd[0] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [31:0] mk(input logic w, input logic [4:0] l, input logic [5:0] p,
                                     input logic [4:0] r, input logic s);
    return (32'(r) << 13) | (32'(p) << 7) | (32'(l) << 2) | (32'(w) << 1) | 32'(s);
  endfunction

  typedef struct packed {
    logic        wr;
    logic [4:0]  lane;
    logic [5:0]  page;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        use_pat;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 5'd3,  6'd5,  5'd7,  16'h1234, 1'b0, 16'h0000},
    '{1'b0, 5'd3,  6'd5,  5'd7,  16'h0000, 1'b0, 16'h1234},
    '{1'b0, 5'd11, 6'd63, 5'd31, 16'h0000, 1'b1, 16'h0000},
    '{1'b1, 5'd0,  6'd0,  5'd0,  16'hFFFF, 1'b0, 16'h0000},
    '{1'b0, 5'd0,  6'd0,  5'd0,  16'h0000, 1'b0, 16'hFFFF},
    '{1'b1, 5'd11, 6'd1,  5'd2,  16'h0A5C, 1'b0, 16'h0000},
    '{1'b0, 5'd11, 6'd1,  5'd2,  16'h0000, 1'b0, 16'h0A5C},
    '{1'b0, 5'd7,  6'd2,  5'd16, 16'h0000, 1'b1, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    int n, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", cmd_rd, 32'h0);
    chk("R1 data", data_rd, 32'h0);
    chk("R1 strobe", 32'(sds_en), 32'h0);

    foreach (VEC[i]) begin
      if (VEC[i].wr) csr_write(1'b1, {16'h0, VEC[i].wd});
      s0 = strobes;
      csr_write(1'b0, mk(VEC[i].wr, VEC[i].lane, VEC[i].page, VEC[i].rg, 1'b1));
      // R2 field layout readback with busy
      chk("R2 cmd readback", cmd_rd, mk(VEC[i].wr, VEC[i].lane, VEC[i].page, VEC[i].rg, 1'b1));
      wait_idle(n);
      // R3 busy length
      chk("R3 busy cycles", 32'(n), 32'(LAT));
      // R4 one access with latched fields
      chk("R4 strobe count", 32'(strobes - s0), 32'd1);
      chk("R4 access fields", 32'(last_acc), 32'({VEC[i].rg, VEC[i].page, VEC[i].lane, VEC[i].wr}));
      if (VEC[i].wr)
        chk("R4 stored value", 32'(mem_rd(VEC[i].lane, VEC[i].page, VEC[i].rg)), 32'(VEC[i].wd));
      else
        // R5 read result in data word
        chk("R5 read data", data_rd,
            {16'h0, VEC[i].use_pat ? pat(h(VEC[i].lane, VEC[i].page, VEC[i].rg)) : VEC[i].exp});
    end

    // R8 upper bits of data word read zero
    csr_write(1'b1, 32'hFFFF_1357);
    chk("R8 data upper", data_rd, 32'h0000_1357);

    // R10 command without start; R8 command upper bits zero
    s0 = strobes;
    csr_write(1'b0, 32'hFFFC_0000 | mk(1'b1, 5'd9, 6'd33, 5'd21, 1'b0));
    repeat (LAT + 2) @(negedge clk);
    chk("R10 fields no busy", cmd_rd, mk(1'b1, 5'd9, 6'd33, 5'd21, 1'b0));
    chk("R10 no access", 32'(strobes - s0), 32'd0);

    // R6 command while busy ignored
    s0 = strobes;
    csr_write(1'b0, mk(1'b0, 5'd3, 6'd5, 5'd7, 1'b1));
    csr_write(1'b0, mk(1'b1, 5'd0, 6'd0, 5'd0, 1'b1));
    chk("R6 fields kept", cmd_rd, mk(1'b0, 5'd3, 6'd5, 5'd7, 1'b1));
    wait_idle(n);
    chk("R6 busy cycles", 32'(n + 1), 32'(LAT));
    chk("R6 single access", 32'(strobes - s0), 32'd1);
    chk("R6 original read", data_rd, 32'h0000_1234);
    chk("R6 no stray write", 32'(mem_rd(5'd0, 6'd0, 5'd0)), 32'h0000_FFFF);

    // R7 data write while busy ignored
    csr_write(1'b1, 32'h0000_7777);
    csr_write(1'b0, mk(1'b1, 5'd2, 6'd3, 5'd4, 1'b1));
    csr_write(1'b1, 32'h0000_1111);
    chk("R7 data held", data_rd, 32'h0000_7777);
    wait_idle(n);
    chk("R7 stored value", 32'(mem_rd(5'd2, 6'd3, 5'd4)), 32'h0000_7777);
    chk("R7 data after", data_rd, 32'h0000_7777);

    // R9 illegal lane read and write
    s0 = strobes;
    csr_write(1'b0, mk(1'b0, 5'd12, 6'd0, 5'd0, 1'b1));
    wait_idle(n);
    chk("R9 busy cycles", 32'(n), 32'(LAT));
    chk("R9 no access rd", 32'(strobes - s0), 32'd0);
    chk("R9 read zero", data_rd, 32'h0);
    csr_write(1'b1, 32'h0000_4321);
    csr_write(1'b0, mk(1'b1, 5'd20, 6'd4, 5'd3, 1'b1));
    wait_idle(n);
    chk("R9 no access wr", 32'(strobes - s0), 32'd0);
    chk("R9 data kept on wr", data_rd, 32'h0000_4321);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule